// File: doc/BRIEF.md
# Timesync Counter with One-Shot Match Output

This block keeps a 64-bit time count that advances by one on every clock while it runs, and drives a single output pin that toggles once when the count reaches a programmed target. Software reaches it through a small 32-bit word-addressed register port. To set the time, software halts the count with a command bit in the control word. It then writes the low and high halves and restarts the count with a second command bit. Each control write re-supplies the pin source field, which was read back beforehand, so the routing survives the halt and restart.

The target is 63 bits wide and is compared against the low 63 bits of the count. The most significant count bit plays no part in the match. Writing the target's upper word with its top bit set arms a one-shot match. When the count equals the target, the arming is consumed. If the control word routes the compare event to the pin, the pin flips its level once. Nothing repeats until software re-arms. Count reads are split in two: reading the low word also captures the high word, so a later read of the high word gives the half that belongs with it.

Top module: `tsync_match_timer`

## Requirements
- R1: After a synchronous reset the count is 0 and running, the pin is 0, read data is 0, and the control field, the target and the compare enable all read back as 0.
- R2: While running, the count increases by exactly 1 on each clock edge.
- R3: Writing the control word (address 0) with bit 1 set halts the count from the next edge. Writing it with bit 2 set restarts it. When both bits are set, the halt wins.
- R4: While halted, a write to address 1 replaces count bits 31:0 and a write to address 2 replaces count bits 63:32. Such writes are ignored while the count is running.
- R5: Every control write stores its bits 17:16 as the pin source field, and a control read returns that field at bits 17:16 with all other bits 0. A halt or restart write that carries the field keeps the routing unchanged.
- R6: Address 3 holds target bits 31:0. Address 4 holds target bits 62:32 in its bits 30:0 and the compare enable in bit 31. Both words read back as written, and count bit 63 is ignored by the compare.
- R7: When the compare is armed and count bits 62:0 equal the target, the arming is consumed. If the source field is 2'b10, the pin inverts on the edge that ends the matching cycle.
- R8: A match fires at most once per arming. A write to address 4 with bit 31 set re-arms the compare, and a write with bit 31 clear disarms it.
- R9: With any source field other than 2'b10 (including 2'b00), the pin holds its level, while a match still consumes the arming.
- R10: A read strobe returns data one cycle later. The data holds until the next read. A read of address 1 returns the live low word and captures the live high word, and a read of address 2 returns the captured word. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ts_pin | output | 1 | One-shot timesync output pin |

## Verification
Every result lands one edge after its cause. Read data appears on the edge that samples the read strobe. A halt, restart or load takes effect on the edge that samples the write. The pin flips on the edge that closes the cycle in which the count equals the target. The bench drives inputs on falling edges and advances its reference model on each rising edge from the same strobes. It then compares the pin and read data on the following falling edge, so every comparison happens after exactly one register stage. The scenario checks wait well past the 32-cycle distance to the target before they sample the pin level.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
   localparam int unsigned ADR_CTRL   = 0;
   localparam int unsigned ADR_CNT_LO = 1;
   localparam int unsigned ADR_CNT_HI = 2;
   localparam int unsigned ADR_TGT_LO = 3;
   localparam int unsigned ADR_TGT_HI = 4;

   localparam int unsigned HALT_BIT   = 1;
   localparam int unsigned RUN_BIT    = 2;
   localparam int unsigned SRC_LSB    = 16;

   localparam logic [1:0]  SRC_WDOG   = 2'b10;
endpackage

// File: rtl/tsync_regs.sv
module tsync_regs
   import tsync_pkg::*;
#(
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CNT_W  = 64,
   localparam int unsigned NHALF = CNT_W / BUS_W,
   localparam int unsigned TGT_W = CNT_W - 1,
   localparam int unsigned HI_TW = TGT_W - BUS_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [CNT_W-1:0]  cnt,
   output logic              halt_p,
   output logic              run_p,
   output logic [NHALF-1:0]  ld_half,
   output logic [1:0]        src_sel,
   output logic [TGT_W-1:0]  tgt,
   output logic              arm_wr,
   output logic              arm_en,
   output logic [BUS_W-1:0]  rdata
);
   logic [1:0]       src_q;
   logic [BUS_W-1:0] tgt_lo_q;
   logic [HI_TW-1:0] tgt_hi_q;
   logic             en_q;
   logic [BUS_W-1:0] shadow_q;
   logic [BUS_W-1:0] rdata_q;
   logic [BUS_W-1:0] rd_val;

   function automatic logic hit_adr(input logic [ADDR_W-1:0] a, input int unsigned tgt_adr);
      return a == ADDR_W'(tgt_adr);
   endfunction

   logic wr_ctrl, wr_tlo, wr_thi, rd_clo;
   assign wr_ctrl = wr && hit_adr(addr, ADR_CTRL);
   assign wr_tlo  = wr && hit_adr(addr, ADR_TGT_LO);
   assign wr_thi  = wr && hit_adr(addr, ADR_TGT_HI);
   assign rd_clo  = rd && hit_adr(addr, ADR_CNT_LO);

   assign halt_p  = wr_ctrl && wdata[HALT_BIT];
   assign run_p   = wr_ctrl && wdata[RUN_BIT];
   assign arm_wr  = wr_thi;
   assign arm_en  = wdata[BUS_W-1];

   for (genvar h = 0; h < NHALF; h++) begin : g_ld
      assign ld_half[h] = wr && hit_adr(addr, ADR_CNT_LO + h);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         src_q    <= '0;
         tgt_lo_q <= '0;
         tgt_hi_q <= '0;
         en_q     <= 1'b0;
      end else begin
         if (wr_ctrl) src_q <= wdata[SRC_LSB +: 2];
         if (wr_tlo)  tgt_lo_q <= wdata;
         if (wr_thi) begin
            tgt_hi_q <= wdata[HI_TW-1:0];
            en_q     <= wdata[BUS_W-1];
         end
      end
   end

   always_comb begin
      rd_val = '0;
      if (hit_adr(addr, ADR_CTRL))        rd_val[SRC_LSB +: 2] = src_q;
      else if (hit_adr(addr, ADR_CNT_LO)) rd_val = cnt[BUS_W-1:0];
      else if (hit_adr(addr, ADR_CNT_HI)) rd_val = shadow_q;
      else if (hit_adr(addr, ADR_TGT_LO)) rd_val = tgt_lo_q;
      else if (hit_adr(addr, ADR_TGT_HI)) rd_val = {en_q, tgt_hi_q};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata_q  <= '0;
         shadow_q <= '0;
      end else if (rd) begin
         rdata_q <= rd_val;
         if (rd_clo) shadow_q <= cnt[CNT_W-1:BUS_W];
      end
   end

   assign src_sel = src_q;
   assign tgt     = {tgt_hi_q, tgt_lo_q};
   assign rdata   = rdata_q;

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      !rd |=> $stable(rdata)) else $error("read data moved without a read"); // R10
   AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      rd_clo |=> shadow_q == $past(cnt[CNT_W-1:BUS_W])) else $error("high word not captured"); // R10
endmodule

// File: rtl/tsync_counter.sv
module tsync_counter #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned BUS_W = 32,
   localparam int unsigned NHALF = CNT_W / BUS_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             halt_p,
   input  logic             run_p,
   input  logic [NHALF-1:0] ld_half,
   input  logic [BUS_W-1:0] ld_data,
   output logic [CNT_W-1:0] cnt
);
   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] step;
   logic [CNT_W-1:0] cnt_nxt;

   assign step = run_q ? cnt_q + CNT_W'(1) : cnt_q;

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      assign cnt_nxt[h*BUS_W +: BUS_W] = (!run_q && ld_half[h]) ? ld_data
                                                                : step[h*BUS_W +: BUS_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else begin
         cnt_q <= cnt_nxt;
         if (halt_p)     run_q <= 1'b0;
         else if (run_p) run_q <= 1'b1;
      end
   end

   assign cnt = cnt_q;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      run_q |=> cnt_q == $past(cnt_q) + CNT_W'(1)) else $error("count did not step"); // R2
   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (!run_q && ld_half == '0) |=> $stable(cnt_q)) else $error("halted count moved"); // R3
   AST_HALT_WINS: assert property (@(posedge clk) disable iff (rst)
      halt_p |=> !run_q) else $error("halt did not stop the count"); // R3
   AST_LOAD_GATED: assert property (@(posedge clk) disable iff (rst)
      (run_q && ld_half != '0) |=> cnt_q == $past(cnt_q) + CNT_W'(1)) else $error("load while running"); // R4
endmodule

// File: rtl/tsync_match.sv
module tsync_match
   import tsync_pkg::*;
#(
   parameter int unsigned TGT_W = 63
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [TGT_W-1:0] cnt_low,
   input  logic [TGT_W-1:0] tgt,
   input  logic             arm_wr,
   input  logic             arm_en,
   input  logic [1:0]       src_sel,
   output logic             pin
);
   logic armed_q;
   logic pin_q;
   logic hit;
   logic route;

   assign hit   = armed_q && (cnt_low == tgt);
   assign route = (src_sel == SRC_WDOG);

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
         pin_q   <= 1'b0;
      end else begin
         if (arm_wr)   armed_q <= arm_en;
         else if (hit) armed_q <= 1'b0;
         if (hit && route) pin_q <= ~pin_q;
      end
   end

   assign pin = pin_q;

   AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (rst)
      (hit && route) |=> pin_q != $past(pin_q)) else $error("pin missed toggle"); // R7
   AST_PIN_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(hit && route) |=> $stable(pin_q)) else $error("pin moved without routed match"); // R9
   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
      (hit && !arm_wr) |=> !armed_q) else $error("arming not consumed"); // R8
   AST_REARM: assert property (@(posedge clk) disable iff (rst)
      arm_wr |=> armed_q == $past(arm_en)) else $error("arm write ignored"); // R8
endmodule

// File: rtl/tsync_match_timer.sv
module tsync_match_timer
   import tsync_pkg::*;
#(
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CNT_W  = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              ts_pin
);
   localparam int unsigned NHALF = CNT_W / BUS_W;
   localparam int unsigned TGT_W = CNT_W - 1;

   initial begin : p_param_chk
      assert (CNT_W == 2 * BUS_W) else $fatal(1, "count must be two bus words");
      assert (BUS_W >= SRC_LSB + 2) else $fatal(1, "bus too narrow for source field");
      assert (ADDR_W >= 3) else $fatal(1, "address too narrow for register map");
   end

   logic             halt_p, run_p, arm_wr, arm_en;
   logic [NHALF-1:0] ld_half;
   logic [1:0]       src_sel;
   logic [TGT_W-1:0] tgt;
   logic [CNT_W-1:0] cnt;

   tsync_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
      .wdata(bus_wdata), .cnt(cnt), .halt_p(halt_p), .run_p(run_p),
      .ld_half(ld_half), .src_sel(src_sel), .tgt(tgt), .arm_wr(arm_wr),
      .arm_en(arm_en), .rdata(bus_rdata)
   );

   tsync_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cnt (
      .clk(clk), .rst(rst), .halt_p(halt_p), .run_p(run_p),
      .ld_half(ld_half), .ld_data(bus_wdata), .cnt(cnt)
   );

   tsync_match #(.TGT_W(TGT_W)) u_match (
      .clk(clk), .rst(rst), .cnt_low(cnt[TGT_W-1:0]), .tgt(tgt),
      .arm_wr(arm_wr), .arm_en(arm_en), .src_sel(src_sel), .pin(ts_pin)
   );

   AST_RESET_PIN: assert property (@(posedge clk)
      rst |=> (ts_pin == 1'b0 && bus_rdata == '0)) else $error("reset state wrong"); // R1
endmodule

// File: tb/tb_tsync_match_timer.sv
module tb_tsync_match_timer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ts_pin;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   tsync_match_timer dut (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ts_pin(ts_pin)
   );

   // behavioural reference
   logic [63:0] m_cnt;
   logic        m_run, m_en, m_arm, m_pin;
   logic [1:0]  m_src;
   logic [62:0] m_tgt;
   logic [31:0] m_rdata, m_shadow;

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0; m_run = 1; m_en = 0; m_arm = 0; m_pin = 0;
         m_src = 0; m_tgt = 0; m_rdata = 0; m_shadow = 0;
      end else begin
         logic        fire;
         logic [63:0] c;
         logic        r;
         fire = m_arm && (m_cnt[62:0] == m_tgt);
         c = m_cnt; r = m_run;
         if (bus_rd) begin
            case (bus_addr)
               3'd0: m_rdata = {14'd0, m_src, 16'd0};
               3'd1: begin m_rdata = m_cnt[31:0]; m_shadow = m_cnt[63:32]; end
               3'd2: m_rdata = m_shadow;
               3'd3: m_rdata = m_tgt[31:0];
               3'd4: m_rdata = {m_en, m_tgt[62:32]};
               default: m_rdata = 0;
            endcase
         end
         if (m_run) c = m_cnt + 1;
         if (fire && m_src == 2'b10) m_pin = ~m_pin;
         if (fire) m_arm = 0;
         if (bus_wr) begin
            case (bus_addr)
               3'd0: begin
                  if (bus_wdata[1]) r = 0; else if (bus_wdata[2]) r = 1;
                  m_src = bus_wdata[17:16];
               end
               3'd1: if (!m_run) c[31:0] = bus_wdata;
               3'd2: if (!m_run) c[63:32] = bus_wdata;
               3'd3: m_tgt[31:0] = bus_wdata;
               3'd4: begin m_tgt[62:32] = bus_wdata[30:0]; m_en = bus_wdata[31]; m_arm = bus_wdata[31]; end
               default: ;
            endcase
         end
         m_cnt = c; m_run = r;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst && !done) begin
         chk("R7 pin vs model", {63'd0, ts_pin}, {63'd0, m_pin});
         chk("R10 rdata vs model", {32'd0, bus_rdata}, {32'd0, m_rdata});
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1; bus_addr = a;
      @(negedge clk); bus_rd = 0; d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reload(input logic [31:0] hi, input logic [31:0] lo);
      wr(3'd1, lo); wr(3'd2, hi);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] a, b, h1, h2;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;
      // R1 reset state
      chk("R1 pin after reset", {63'd0, ts_pin}, 64'd0);
      chk("R1 rdata after reset", {32'd0, bus_rdata}, 64'd0);
      rd(3'd0, a); chk("R1 ctrl field", {32'd0, a}, 64'd0);
      rd(3'd4, a); chk("R1 target high", {32'd0, a}, 64'd0);
      // R2 counting
      rd(3'd1, a); idle(5); rd(3'd1, b);
      chk("R2 count step over 7 edges", {32'd0, b - a}, 64'd7);
      // R3 halt, restart, halt wins
      wr(3'd0, 32'h2);
      rd(3'd1, a); idle(5); rd(3'd1, b);
      chk("R3 halted count frozen", {32'd0, b - a}, 64'd0);
      wr(3'd0, 32'h4);
      rd(3'd1, a); idle(5); rd(3'd1, b);
      chk("R3 restarted count", {32'd0, b - a}, 64'd7);
      wr(3'd0, 32'h6);
      rd(3'd1, a); idle(5); rd(3'd1, b);
      chk("R3 halt wins over restart", {32'd0, b - a}, 64'd0);
      // R4 load while halted, ignored while running
      reload(32'h12, 32'h10);
      rd(3'd1, a); chk("R4 loaded low", {32'd0, a}, 64'h10);
      rd(3'd2, a); chk("R4 loaded high", {32'd0, a}, 64'h12);
      wr(3'd0, 32'h4);
      wr(3'd2, 32'h5);
      rd(3'd1, a); rd(3'd2, b);
      chk("R4 high write ignored while running", {32'd0, b}, 64'h12);
      // R10 consistent pair across a carry
      wr(3'd0, 32'h2);
      reload(32'h7, 32'hFFFF_FFFE);
      wr(3'd0, 32'h4);
      rd(3'd1, a); rd(3'd2, h1);
      chk("R10 pair before carry", {32'd0, h1}, (a >= 32'hFFFF_FFF0) ? 64'h7 : 64'h8);
      idle(3);
      rd(3'd1, a); rd(3'd2, h2);
      chk("R10 pair after carry", {32'd0, h2}, (a >= 32'hFFFF_FFF0) ? 64'h7 : 64'h8);
      rd(3'd2, b); chk("R10 captured word stable", {32'd0, b}, {32'd0, h2});
      rd(3'd6, a); chk("R10 unmapped reads 0", {32'd0, a}, 64'd0);
      // R5 source field kept through halt and restart
      wr(3'd0, 32'h0002_0000);
      rd(3'd0, a); chk("R5 field readback", {32'd0, a}, 64'h0002_0000);
      wr(3'd0, 32'h0002_0002);
      rd(3'd0, a); chk("R5 field kept by halt", {32'd0, a}, 64'h0002_0000);
      // R6 R7 match with count bit 63 set
      reload(32'h8000_0000, 32'h100);
      wr(3'd3, 32'h120); wr(3'd4, 32'h8000_0000);
      rd(3'd3, a); chk("R6 target low readback", {32'd0, a}, 64'h120);
      rd(3'd4, a); chk("R6 target high readback", {32'd0, a}, 64'h8000_0000);
      wr(3'd0, 32'h0002_0004);
      rd(3'd0, a); chk("R5 field kept by restart", {32'd0, a}, 64'h0002_0000);
      chk("R7 pin low before match", {63'd0, ts_pin}, 64'd0);
      idle(50);
      chk("R7 pin toggled on match", {63'd0, ts_pin}, 64'd1);
      // R8 one shot, re-arm, disarm
      wr(3'd0, 32'h0002_0002); reload(32'h8000_0000, 32'h100); wr(3'd0, 32'h0002_0004);
      idle(50);
      chk("R8 no second toggle without re-arm", {63'd0, ts_pin}, 64'd1);
      wr(3'd0, 32'h0002_0002); reload(32'h8000_0000, 32'h100);
      wr(3'd4, 32'h8000_0000); wr(3'd0, 32'h0002_0004);
      idle(50);
      chk("R8 re-armed toggle", {63'd0, ts_pin}, 64'd0);
      wr(3'd0, 32'h0002_0002); reload(32'h8000_0000, 32'h100);
      wr(3'd4, 32'h0); wr(3'd0, 32'h0002_0004);
      idle(50);
      chk("R8 disarmed no toggle", {63'd0, ts_pin}, 64'd0);
      // R9 unrouted match holds pin and consumes arming
      wr(3'd0, 32'h2); reload(32'h8000_0000, 32'h100);
      wr(3'd4, 32'h8000_0000); wr(3'd0, 32'h4);
      idle(50);
      chk("R9 field 00 holds pin", {63'd0, ts_pin}, 64'd0);
      wr(3'd0, 32'h0002_0002); reload(32'h8000_0000, 32'h100); wr(3'd0, 32'h0002_0004);
      idle(50);
      chk("R9 arming consumed while unrouted", {63'd0, ts_pin}, 64'd0);
      wr(3'd0, 32'h0001_0002); reload(32'h8000_0000, 32'h100);
      wr(3'd4, 32'h8000_0000); wr(3'd0, 32'h0001_0004);
      idle(50);
      chk("R9 field 01 holds pin", {63'd0, ts_pin}, 64'd0);
      idle(2);
      finish_run();
   end
endmodule